// File: doc/BRIEF.md
# Ethernet Link Status LED Controller

This block drives the three indicator lamps of an Ethernet PHY: one for link presence, one for traffic and one for line rate. All three outputs are active-low, so a lit lamp is driven low. Its inputs are a link-valid flag, a resolved-rate flag (high for 100 Mb/s, low for 10 Mb/s), a single-cycle traffic strobe and a two-bit rate-mode selector. All inputs are synchronous to the block clock. Each output comes from a register, so it changes after the first clock edge that samples the input.

The rate lamp follows the resolved rate while the link is up. When the link drops in negotiated mode, the lamp keeps the rate that was last seen with a valid link. The two forced modes fix the lamp on or off whatever the link does. A traffic strobe starts a hold timer of `HOLD_CYC` cycles. While the timer runs, the traffic lamp blinks with a half-period of 2^`HALF_LOG2` cycles. When the timer runs out, the lamp goes dark.

Top module: `phy_led_drv`

## Requirements
- R1: While `rst` is high, and after it is released, all three outputs are high (dark). The stored last-valid rate is cleared to 10 Mb/s, so in negotiated mode with the link down the rate lamp stays dark.
- R2: `led_link_n` equals the inverse of `link_ok` sampled at the previous rising edge.
- R3: In negotiated mode with `link_ok` high, `led_spd_n` after the edge is low if `spd_fast` was 1 and high if it was 0. The mode code is `mode` = 2'b00.
- R4: In negotiated mode with `link_ok` low, `led_spd_n` shows the rate of the last edge at which `link_ok` was high, in any mode. The stored rate is updated at every edge where `link_ok` is high.
- R5: With `mode` = 2'b01 (forced 100) at an edge, `led_spd_n` is low after that edge, whatever `link_ok` and `spd_fast` are.
- R6: With `mode` = 2'b10 (forced 10) at an edge, `led_spd_n` is high after that edge, whatever `link_ok` and `spd_fast` are.
- R7: The mode code 2'b11 behaves exactly like negotiated mode.
- R8: Take a strobe sampled at edge k while the hold timer is idle, and count j edges after k with no further strobe. For j < `HOLD_CYC`, `led_act_n` is low when (j mod 2^(`HALF_LOG2`+1)) < 2^`HALF_LOG2` and high otherwise.
- R9: A strobe sampled while the hold timer runs reloads the timer to `HOLD_CYC` and does not restart the blink phase. The phase keeps counting one step per edge from the start of the burst.
- R10: Once `HOLD_CYC` edges have passed since the last strobe, `led_act_n` is high and stays high until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| link_ok | input | 1 | Link-valid flag |
| spd_fast | input | 1 | Resolved rate: 1 = 100 Mb/s, 0 = 10 Mb/s |
| act_pulse | input | 1 | One-cycle traffic strobe |
| mode | input | 2 | 00 negotiated, 01 forced 100, 10 forced 10, 11 negotiated |
| led_link_n | output | 1 | Link lamp, active low |
| led_act_n | output | 1 | Traffic lamp, active low |
| led_spd_n | output | 1 | Rate lamp, active low |

## Verification
Every result is due one edge after the edge that samples its stimulus. The link and rate lamps reflect that edge's inputs, and the traffic lamp reflects the timer and phase state after that edge. The bench therefore drives inputs on the falling edge and samples outputs on the next falling edge, half a period after the sampling edge. For the traffic lamp, the bench counts the edges since the last strobe and since the start of the burst, and compares each cycle against the blink rule. It continues until several cycles past expiry, so the first dark cycle after the hold is also checked.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

    typedef enum logic [1:0] {
        MODE_NEG     = 2'b00,
        MODE_FIX100  = 2'b01,
        MODE_FIX10   = 2'b10,
        MODE_NEG_ALT = 2'b11
    } led_mode_e;

    typedef struct packed {
        logic link_on;
        logic act_on;
        logic spd_on;
    } lamp_t;

    // Rate lamp decision: forced modes win, otherwise live rate or held rate.
    function automatic logic pick_speed(led_mode_e m, logic link, logic fast, logic held);
        logic on;
        case (m)
            MODE_FIX100: on = 1'b1;
            MODE_FIX10:  on = 1'b0;
            default:     on = link ? fast : held;
        endcase
        return on;
    endfunction

endpackage

// File: rtl/link_lamp.sv
module link_lamp (
    input  logic clk,
    input  logic rst,
    input  logic link_ok,
    output logic link_on
);
    always_ff @(posedge clk) begin
        if (rst) link_on <= 1'b0;
        else     link_on <= link_ok;
    end
endmodule

// File: rtl/speed_lamp.sv
module speed_lamp
    import phy_led_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  led_mode_e mode,
    input  logic      link_ok,
    input  logic      spd_fast,
    output logic      spd_on
);
    logic held_fast;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_fast <= 1'b0;
            spd_on    <= 1'b0;
        end else begin
            if (link_ok) held_fast <= spd_fast;
            spd_on <= pick_speed(mode, link_ok, spd_fast, held_fast);
        end
    end
endmodule

// File: rtl/act_blink.sv
module act_blink #(
    parameter int HALF_LOG2 = 22,
    parameter int HOLD_CYC  = 1 << 24
) (
    input  logic clk,
    input  logic rst,
    input  logic act_pulse,
    output logic act_on
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);
    localparam int PH_W   = HALF_LOG2 + 1;
    localparam logic [HOLD_W-1:0] HOLD_LD = HOLD_W'(HOLD_CYC);

    logic [HOLD_W-1:0] hold_cnt;
    logic [PH_W-1:0]   phase;
    logic              running;

    assign running = (hold_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            phase    <= '0;
        end else begin
            if (act_pulse)    hold_cnt <= HOLD_LD;
            else if (running) hold_cnt <= hold_cnt - 1'b1;

            if (running) phase <= phase + 1'b1;
            else         phase <= '0;
        end
    end

    // Lit in the first half of each blink period while the hold runs.
    assign act_on = running && !phase[PH_W-1];
endmodule

// File: rtl/phy_led_drv.sv
module phy_led_drv
    import phy_led_pkg::*;
#(
    parameter int HALF_LOG2 = 22,
    parameter int HOLD_CYC  = 1 << 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       link_ok,
    input  logic       spd_fast,
    input  logic       act_pulse,
    input  logic [1:0] mode,
    output logic       led_link_n,
    output logic       led_act_n,
    output logic       led_spd_n
);
    lamp_t     lamps;
    led_mode_e mode_e;

    assign mode_e = led_mode_e'(mode);

    link_lamp u_link (
        .clk     (clk),
        .rst     (rst),
        .link_ok (link_ok),
        .link_on (lamps.link_on)
    );

    speed_lamp u_spd (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_e),
        .link_ok  (link_ok),
        .spd_fast (spd_fast),
        .spd_on   (lamps.spd_on)
    );

    act_blink #(
        .HALF_LOG2 (HALF_LOG2),
        .HOLD_CYC  (HOLD_CYC)
    ) u_act (
        .clk       (clk),
        .rst       (rst),
        .act_pulse (act_pulse),
        .act_on    (lamps.act_on)
    );

    assign led_link_n = ~lamps.link_on;
    assign led_act_n  = ~lamps.act_on;
    assign led_spd_n  = ~lamps.spd_on;
endmodule

// File: rtl/phy_led_chk.sv
module phy_led_chk #(
    parameter int HOLD_CYC = 1 << 24
) (
    input logic       clk,
    input logic       rst,
    input logic       link_ok,
    input logic       spd_fast,
    input logic       act_pulse,
    input logic [1:0] mode,
    input logic       led_link_n,
    input logic       led_act_n,
    input logic       led_spd_n
);
    logic        arm1, arm2;
    logic [31:0] since;
    logic        neg_now;

    assign neg_now = (mode == 2'b00) || (mode == 2'b11);

    always_ff @(posedge clk) begin
        if (rst) begin
            arm1  <= 1'b0;
            arm2  <= 1'b0;
            since <= 32'(HOLD_CYC);
        end else begin
            arm1 <= 1'b1;
            arm2 <= arm1;
            if (act_pulse)                  since <= '0;
            else if (since < 32'(HOLD_CYC)) since <= since + 1;
        end
    end

    // R1
    reset_dark_chk: assert property (@(posedge clk)
        $past(rst) |-> (led_link_n && led_act_n && led_spd_n));

    // R2
    link_follow_chk: assert property (@(posedge clk) disable iff (rst)
        arm1 |-> (led_link_n == !$past(link_ok)));

    // R3
    live_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (arm1 && $past(link_ok && neg_now)) |-> (led_spd_n == !$past(spd_fast)));

    // R4
    held_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (arm2 && $past(!link_ok && neg_now) && $past(neg_now, 2)) |-> $stable(led_spd_n));

    // R5
    force_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (arm1 && $past(mode == 2'b01)) |-> !led_spd_n);

    // R6
    force_slow_chk: assert property (@(posedge clk) disable iff (rst)
        (arm1 && $past(mode == 2'b10)) |-> led_spd_n);

    // R8
    first_lit_chk: assert property (@(posedge clk) disable iff (rst)
        (arm1 && $past(act_pulse && since >= 32'(HOLD_CYC))) |-> !led_act_n);

    // R10
    expired_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (arm1 && since >= 32'(HOLD_CYC)) |-> led_act_n);
endmodule

bind phy_led_drv phy_led_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .link_ok    (link_ok),
    .spd_fast   (spd_fast),
    .act_pulse  (act_pulse),
    .mode       (mode),
    .led_link_n (led_link_n),
    .led_act_n  (led_act_n),
    .led_spd_n  (led_spd_n)
);

// File: tb/sim_phy_led_drv.sv
`timescale 1ns/1ps
module sim_phy_led_drv;
    localparam int HALF_LOG2 = 2;
    localparam int HOLD_CYC  = 20;
    localparam int HALF      = 1 << HALF_LOG2;
    localparam int PERIOD2   = 2 * HALF;
    localparam int NVEC      = 15;

    // {mode[1:0], link_ok, spd_fast, exp_link_n, exp_spd_n}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b00_0_1_1_1, // R4 held rate cleared by reset
        6'b00_1_1_0_0, // R3
        6'b00_1_0_0_1, // R3
        6'b00_1_1_0_0, // R3
        6'b00_0_0_1_0, // R4 hold 100
        6'b00_0_0_1_0, // R4
        6'b10_0_1_1_1, // R6
        6'b10_1_1_0_1, // R6 (stores 100)
        6'b01_1_0_0_0, // R5 (stores 10)
        6'b01_0_0_1_0, // R5
        6'b00_0_1_1_1, // R4 hold 10
        6'b11_1_1_0_0, // R7
        6'b11_0_0_1_0, // R7 hold
        6'b10_0_0_1_1, // R6
        6'b00_0_0_1_0  // R4
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       link_ok = 1'b0, spd_fast = 1'b0, act_pulse = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       led_link_n, led_act_n, led_spd_n;

    int nchk = 0, nfail = 0;
    int since = HOLD_CYC, burst = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    phy_led_drv #(.HALF_LOG2(HALF_LOG2), .HOLD_CYC(HOLD_CYC)) u0 (
        .clk(clk), .rst(rst), .link_ok(link_ok), .spd_fast(spd_fast),
        .act_pulse(act_pulse), .mode(mode),
        .led_link_n(led_link_n), .led_act_n(led_act_n), .led_spd_n(led_spd_n)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string rate_tag(input logic [1:0] m, input logic l);
        case (m)
            2'b01:   return "R5 forced 100";
            2'b10:   return "R6 forced 10";
            2'b11:   return "R7 alt code";
            default: return l ? "R3 live rate" : "R4 held rate";
        endcase
    endfunction

    // One clock of traffic stimulus with the blink model and a check.
    task automatic act_step(input logic p, input string tag);
        act_pulse = p;
        @(posedge clk);
        @(negedge clk);
        act_pulse = 1'b0;
        if (p) begin
            if (since >= HOLD_CYC) burst = 0; else burst++;
            since = 0;
        end else begin
            if (since < HOLD_CYC) since++;
            burst++;
        end
        check(tag, led_act_n, !((since < HOLD_CYC) && ((burst % PERIOD2) < HALF)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 link dark in reset", led_link_n, 1'b1);
        check("R1 act dark in reset", led_act_n, 1'b1);
        check("R1 rate dark in reset", led_spd_n, 1'b1);
        rst = 1'b0;

        // Vector table for link and rate lamps
        for (int i = 0; i < NVEC; i++) begin
            mode     = VEC[i][5:4];
            link_ok  = VEC[i][3];
            spd_fast = VEC[i][2];
            @(posedge clk);
            @(negedge clk);
            check("R2 link lamp", led_link_n, VEC[i][1]);
            check(rate_tag(VEC[i][5:4], VEC[i][3]), led_spd_n, VEC[i][0]);
        end

        // Single burst through expiry
        act_step(1'b1, "R8 burst start");
        for (int j = 1; j < HOLD_CYC; j++) act_step(1'b0, "R8 blink");
        for (int j = 0; j < 6; j++) act_step(1'b0, "R10 expired");

        // Retrigger mid-burst, phase continues
        act_step(1'b1, "R8 burst start");
        for (int j = 1; j < 10; j++) act_step(1'b0, "R8 blink");
        act_step(1'b1, "R9 retrigger");
        for (int j = 1; j < HOLD_CYC; j++) act_step(1'b0, "R9 extended hold");
        for (int j = 0; j < 4; j++) act_step(1'b0, "R10 expired");

        // Retrigger on the last running cycle
        act_step(1'b1, "R8 burst start");
        for (int j = 1; j < HOLD_CYC; j++) act_step(1'b0, "R8 blink");
        act_step(1'b1, "R9 retrigger at edge of expiry");
        for (int j = 0; j < HOLD_CYC + 3; j++) act_step(1'b0, "R10 after retrigger");

        // Mid-run reset clears lamps and held rate
        mode = 2'b00; link_ok = 1'b1; spd_fast = 1'b1;
        act_step(1'b1, "R8 burst start");
        check("R3 live rate before reset", led_spd_n, 1'b0);
        link_ok = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 link dark after reset", led_link_n, 1'b1);
        check("R1 act dark after reset", led_act_n, 1'b1);
        check("R1 rate dark after reset", led_spd_n, 1'b1);
        rst = 1'b0;
        since = HOLD_CYC;
        burst = 0;
        @(posedge clk);
        @(negedge clk);
        check("R1 held rate cleared", led_spd_n, 1'b1);
        check("R10 idle after reset", led_act_n, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule